// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This block keeps the status byte of a serial memory device and decides, in every cycle, whether a write may proceed. A command decoder outside the block hands it single-cycle strobes: one that arms the write latch, one that disarms it, one that asks to load a new status byte, and one that reports a finished array write. From these strobes, the stored protection bits, a hardware protect pin and an external busy flag, it forms two permission outputs. One says whether a given 13-bit array address may be written. The other says whether the status byte may be written.

The stored protection settings are the pin-enable bit and two block-protect bits. They model nonvolatile cells, so only the power-on reset clears them. A status write changes them only when the status permission is granted in the same cycle. The hardware pin can lock the status byte, but it never affects array permission. The busy flag shows up as bit 0 of the status byte. While busy is high, both permissions are withheld.

Top module: `status_guard`

## Requirements
- R1: The status read value is laid out as bit 7 = pin-enable, bits 6 to 4 = always 0, bit 3 = block-protect high bit, bit 2 = block-protect low bit, bit 1 = write latch, bit 0 = the busy input.
- R2: After power-on reset, pin-enable, both block-protect bits and the write latch are all 0.
- R3: A set-enable strobe sets the latch from the next cycle, and a clear-enable strobe clears it. Both act whatever the pin and pin-enable are. When both strobes arrive in the same cycle, clear wins.
- R4: While the latch is 0, both array and status permission are 0.
- R5: While busy is 1, both permissions are 0.
- R6: With the latch set and busy low, array permission depends on the block-protect bits {bit3,bit2}. The value 00 allows every address. The value 01 blocks 1800h to 1FFFh. The value 10 blocks 1000h to 1FFFh. The value 11 blocks every address.
- R7: With the latch set and busy low, status permission is 0 exactly when pin-enable is 1 and the pin is low. The pin never changes array permission.
- R8: A status write strobe that arrives while status permission is 1 stores data bits 7, 3 and 2 into pin-enable and the block-protect bits. All other data bits are ignored. The latch reads 0 from the next cycle.
- R9: A status write strobe that arrives while status permission is 0 changes no stored bit and leaves the latch as it was.
- R10: An array-write-done strobe clears the latch from the next cycle. Any strobe that clears the latch takes priority over set-enable in the same cycle.
- R11: Pin transitions never change the stored pin-enable or block-protect bits, including pin changes while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| setEnStb | input | 1 | Set-enable strobe |
| clrEnStb | input | 1 | Clear-enable strobe |
| wrStatStb | input | 1 | Status write request strobe |
| wrStatData | input | 8 | Byte offered with the status write |
| arrWrDoneStb | input | 1 | Array write completed strobe |
| protPin | input | 1 | Hardware protect pin, low means protect |
| busy | input | 1 | Internal write in progress |
| chkAddr | input | 13 | Array address being checked |
| statRd | output | 8 | Status byte read value |
| arrWrOk | output | 1 | Array write allowed at chkAddr |
| statWrOk | output | 1 | Status write allowed |

## Verification
A wrong latch or a wrong stored protection bit is visible on the status byte in the same cycle. It also shows on one of the two permission outputs, combinationally, as soon as the address or pin visits the affected region. The bench compares all three outputs in every cycle against a model built from the requirements. Any divergence in the latch or the stored bits is therefore caught one cycle after the strobe that caused it. Directed sequences cover the permission corners: the region boundaries at 0FFFh/1000h and 17FFh/1800h, the pin lock, and strobes that collide in one cycle.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef struct packed {
    logic loadStat;
    logic clrWel;
    logic setWel;
  } sgStb_t;

  localparam int STAT_W = 8;
endpackage

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sgStb_t            stb,
  input  logic [STAT_W-1:0] wrData,
  output logic              welQ,
  output logic              peQ,
  output logic [1:0]        bpQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ <= 1'b0;
      peQ  <= 1'b0;
      bpQ  <= 2'b00;
    end else begin
      if (stb.clrWel)      welQ <= 1'b0;
      else if (stb.setWel) welQ <= 1'b1;
      if (stb.loadStat) begin
        peQ <= wrData[7];
        bpQ <= wrData[3:2];
      end
    end
  end

  AST_KEEP_PROT: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadStat |=> ($stable(peQ) && $stable(bpQ))); // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrWel |=> !welQ); // R10
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setEnStb,
  input  logic              clrEnStb,
  input  logic              wrStatStb,
  input  logic              arrWrDoneStb,
  input  logic              protPin,
  input  logic              busy,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic              welQ,
  input  logic              peQ,
  input  logic [1:0]        bpQ,
  output sgStb_t            stb,
  output logic              arrWrOk,
  output logic              statWrOk
);
  localparam int TOP = ADDR_W - 1;

  logic inQuarter, inHalf, blocked, pinLock;

  always_comb begin
    inQuarter = chkAddr[TOP] & chkAddr[TOP-1];
    inHalf    = chkAddr[TOP];
    unique case (bpQ)
      2'b00:   blocked = 1'b0;
      2'b01:   blocked = inQuarter;
      2'b10:   blocked = inHalf;
      default: blocked = 1'b1;
    endcase
    pinLock  = peQ & ~protPin;
    arrWrOk  = welQ & ~busy & ~blocked;
    statWrOk = welQ & ~busy & ~pinLock;

    stb.loadStat = wrStatStb & statWrOk;
    stb.clrWel   = clrEnStb | stb.loadStat | arrWrDoneStb;
    stb.setWel   = setEnStb & ~stb.clrWel;
  end

  AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!arrWrOk && !statWrOk)); // R5
  AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (bpQ == 2'b11) |-> !arrWrOk); // R6
endmodule

// File: rtl/status_guard.sv
module status_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setEnStb,
  input  logic              clrEnStb,
  input  logic              wrStatStb,
  input  logic [7:0]        wrStatData,
  input  logic              arrWrDoneStb,
  input  logic              protPin,
  input  logic              busy,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic [7:0]        statRd,
  output logic              arrWrOk,
  output logic              statWrOk
);
  sgStb_t     stb;
  logic       welQ, peQ;
  logic [1:0] bpQ;

  sg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .setEnStb(setEnStb), .clrEnStb(clrEnStb),
    .wrStatStb(wrStatStb), .arrWrDoneStb(arrWrDoneStb), .protPin(protPin),
    .busy(busy), .chkAddr(chkAddr), .welQ(welQ), .peQ(peQ), .bpQ(bpQ),
    .stb(stb), .arrWrOk(arrWrOk), .statWrOk(statWrOk)
  );

  sg_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrStatData),
    .welQ(welQ), .peQ(peQ), .bpQ(bpQ)
  );

  assign statRd = {peQ, 3'b000, bpQ, welQ, busy};

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    statRd[6:4] == 3'b000); // R1
  AST_NO_WEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !statRd[1] |-> (!arrWrOk && !statWrOk)); // R4
  AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (statRd[7] && !protPin && wrStatStb) |=> $stable(statRd[7:2])); // R7
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatStb && statWrOk) |=> !statRd[1]); // R8
  AST_SET_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (setEnStb && !clrEnStb && !wrStatStb && !arrWrDoneStb) |=> statRd[1]); // R3
endmodule

// File: tb/status_guard_tb.sv
module status_guard_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setEnStb = 0, clrEnStb = 0, wrStatStb = 0, arrWrDoneStb = 0;
  logic protPin = 1, busy = 0;
  logic [7:0] wrStatData = 0;
  logic [12:0] chkAddr = 0;
  logic [7:0] statRd;
  logic arrWrOk, statWrOk;

  int checks = 0, errors = 0;
  logic mWel = 0, mPe = 0;
  logic [1:0] mBp = 0;

  always #4 clk = ~clk;

  status_guard u_dut (
    .clk(clk), .rstN(rstN), .setEnStb(setEnStb), .clrEnStb(clrEnStb),
    .wrStatStb(wrStatStb), .wrStatData(wrStatData), .arrWrDoneStb(arrWrDoneStb),
    .protPin(protPin), .busy(busy), .chkAddr(chkAddr),
    .statRd(statRd), .arrWrOk(arrWrOk), .statWrOk(statWrOk)
  );

  function automatic logic expArr(input logic [12:0] a, input logic b);
    logic blk;
    case (mBp)
      2'b00: blk = 1'b0;
      2'b01: blk = (a >= 13'h1800);
      2'b10: blk = (a >= 13'h1000);
      default: blk = 1'b1;
    endcase
    return mWel && !b && !blk;
  endfunction

  function automatic logic expStat(input logic p, input logic b);
    return mWel && !b && !(mPe && !p);
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic c, input logic w, input logic [7:0] d,
                      input logic ad, input logic p, input logic b, input logic [12:0] a,
                      input string tag);
    logic okS;
    @(negedge clk);
    setEnStb = s; clrEnStb = c; wrStatStb = w; wrStatData = d;
    arrWrDoneStb = ad; protPin = p; busy = b; chkAddr = a;
    #1;
    chk(tag, "statRd", statRd, {mPe, 3'b000, mBp, mWel, b});
    chk(tag, "arrWrOk", {7'd0, arrWrOk}, {7'd0, expArr(a, b)});
    chk(tag, "statWrOk", {7'd0, statWrOk}, {7'd0, expStat(p, b)});
    okS = expStat(p, b);
    @(posedge clk);
    if (w && okS) begin mPe = d[7]; mBp = d[3:2]; end
    if (c || (w && okS) || ad) mWel = 1'b0;
    else if (s) mWel = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "reset statRd", statRd, 8'h00);
    @(negedge clk); rstN = 1'b1;
    // R3: set, then collide set and clear
    step(1,0,0,8'h00,0,1,0,13'h0000,"R3");
    step(1,1,0,8'h00,0,1,0,13'h0000,"R3");
    step(0,0,0,8'h00,0,1,0,13'h0000,"R3");
    // R4: no latch, nothing writable
    step(0,0,1,8'h8C,0,1,0,13'h0123,"R4");
    // R5: busy blocks
    step(1,0,0,8'h00,0,1,0,13'h0000,"R3");
    step(0,0,1,8'h84,0,1,1,13'h0000,"R5");
    // R8: accepted write, 01 protect, don't-care data bits ignored (R1)
    step(0,0,1,8'h77,0,1,0,13'h0000,"R8");
    step(0,0,0,8'h00,0,1,0,13'h0000,"R1");
    // R6: boundaries under 01
    step(1,0,0,8'h00,0,1,0,13'h17FF,"R6");
    step(0,0,0,8'h00,0,1,0,13'h17FF,"R6");
    step(0,0,0,8'h00,0,1,0,13'h1800,"R6");
    // R10: array done clears latch, beats set
    step(1,0,0,8'h00,1,1,0,13'h0000,"R10");
    step(1,0,0,8'h00,0,1,0,13'h0FFF,"R10");
    // set 10 with pin-enable
    step(0,0,1,8'h88,0,1,0,13'h0FFF,"R8");
    step(1,0,0,8'h00,0,1,0,13'h0FFF,"R6");
    step(0,0,0,8'h00,0,1,0,13'h0FFF,"R6");
    step(0,0,0,8'h00,0,1,0,13'h1000,"R6");
    // R7/R9: pin low locks status, array unaffected, latch kept
    step(0,0,1,8'h0C,0,0,0,13'h0FFF,"R7");
    step(0,0,0,8'h00,0,0,0,13'h0FFF,"R9");
    // R11: pin toggles while busy
    step(0,0,0,8'h00,0,1,1,13'h0000,"R11");
    step(0,0,0,8'h00,0,0,1,13'h0000,"R11");
    step(0,0,0,8'h00,0,1,0,13'h0000,"R11");
    // R3: clear while pin-locked
    step(0,1,0,8'h00,0,0,0,13'h0000,"R3");
    step(1,0,0,8'h00,0,0,0,13'h0000,"R3");
    step(0,0,0,8'h00,0,0,0,13'h0000,"R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      step(r == 0 || r == 1 || r == 2 || r == 3, r == 4, r == 5 || r == 6, 8'($urandom),
           r == 7, ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0),
           13'($urandom), "R6");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule